// File: doc/BRIEF.md
# Two-Level Page Table Walker

On a translation miss this block fetches the mapping for a 32-bit virtual address from a two-level page table kept in physical memory. A miss enters on a valid/ready channel. The walker then issues one or two memory reads on a request channel and collects the words that come back on a response channel. It ends each walk with a one-cycle pulse: either a completed result carrying the physical page number and the permission bits, or a page fault that names the level where the walk stopped. The reads are physical addresses and are never translated.

The virtual address splits into three fields. Bits 31:22 index the first-level table, bits 21:12 index the second-level table, and bits 11:0 are the byte offset within the page. Each table entry is 4 bytes wide, so an entry address is the table base plus four times its index. The walker handles one miss at a time.

Back-pressure rules are as follows. A miss is accepted on a clock edge where `miss_valid` and `miss_ready` are both high. `miss_ready` is high only while the walker is idle. A memory request is transferred on an edge where `mem_req_valid` and `mem_req_ready` are both high. Until that edge, the request stays valid and its address stays unchanged. The response channel has no ready signal, because the walker is always able to take the one word it is waiting for. A response that arrives when no read is outstanding is dropped.

Top module: `ptw_top`

## Requirements
- R1: `miss_ready` is high exactly when the walker is idle. A miss offered while a walk is in progress is not taken and does not change the current walk's reads or result.
- R2: The first read goes to `pt_base + 4*va[31:22]`.
- R3: If the first-level entry is present, the second read goes to `{entry[31:12], 12'h000} + 4*va[21:12]`.
- R4: A first-level entry with bit 0 (present) clear ends the walk with `walk_fault` high and `fault_lvl` = 0. No second read is issued.
- R5: A second-level entry with bit 0 clear ends the walk with `walk_fault` high and `fault_lvl` = 1.
- R6: A present second-level entry ends the walk with `walk_done` high. At that point `res_ppn` = entry[31:12], `res_perm` = entry[3:1] (bit 1 read, bit 2 write, bit 3 execute), and `res_pa` = `{entry[31:12], va[11:0]}`.
- R7: `busy` rises in the cycle after the miss is accepted and stays high through the end pulse. It falls in the cycle after that pulse. `walk_done` and `walk_fault` each last one cycle and are never high together.
- R8: Once `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid on the next cycle with the same address.
- R9: The base value is captured when the miss is accepted. A change of `pt_base` during a walk affects only later walks.
- R10: A response that arrives while a request is still waiting for `mem_req_ready` is ignored and does not end the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss offered |
| miss_ready | output | 1 | Walker idle and able to take a miss |
| miss_va | input | 32 | Virtual address of the miss |
| pt_base | input | 32 | Physical base of the first-level table |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word read back |
| busy | output | 1 | Walk in progress |
| walk_done | output | 1 | One-cycle pulse: translation found |
| walk_fault | output | 1 | One-cycle pulse: page fault |
| fault_lvl | output | 1 | Level of the last fault (0 first, 1 second) |
| res_ppn | output | 20 | Physical page number of the last completed walk |
| res_perm | output | 3 | Read, write and execute bits (bit 0 read) |
| res_pa | output | 32 | Physical address of the last completed walk |

## Verification
A corrupted walk state shows up on the request channel first. A read goes to the wrong table, a second read follows a fault, or a request drops while stalled, and each of these is visible within one cycle of the faulty transition. A wrong latched base or table pointer shows as a wrong request address on the next read, and a wrong leaf capture shows as a wrong result on the done pulse, at most one cycle after the final response. A stuck state shows as `busy` never falling and `miss_ready` never returning.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE,
    ST_FAULT
  } walk_st_t;

  localparam int unsigned PTE_PRESENT_BIT = 0;
  localparam int unsigned PTE_PERM_LSB    = 1;
  localparam int unsigned NUM_LEVELS      = 2;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     miss_valid,
  input  logic     req_ready,
  input  logic     rsp_valid,
  input  logic     rsp_present,
  output logic     accept,
  output logic     ld_tbl,
  output logic     ld_leaf,
  output logic     flt_set,
  output logic     flt_lvl2,
  output logic     idle,
  output logic     req_valid,
  output logic     req_lvl2,
  output logic     done_pulse,
  output logic     fault_pulse
);
  walk_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (miss_valid) st_d = ST_L1_REQ;
      ST_L1_REQ:  if (req_ready) st_d = ST_L1_WAIT;
      ST_L1_WAIT: if (rsp_valid) st_d = rsp_present ? ST_L2_REQ : ST_FAULT;
      ST_L2_REQ:  if (req_ready) st_d = ST_L2_WAIT;
      ST_L2_WAIT: if (rsp_valid) st_d = rsp_present ? ST_DONE : ST_FAULT;
      ST_DONE:    st_d = ST_IDLE;
      ST_FAULT:   st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  logic waiting;
  assign waiting     = (st_q == ST_L1_WAIT) || (st_q == ST_L2_WAIT);
  assign idle        = (st_q == ST_IDLE);
  assign accept      = idle && miss_valid;
  assign ld_tbl      = (st_q == ST_L1_WAIT) && rsp_valid && rsp_present;
  assign ld_leaf     = (st_q == ST_L2_WAIT) && rsp_valid && rsp_present;
  assign flt_set     = waiting && rsp_valid && !rsp_present;
  assign flt_lvl2    = (st_q == ST_L2_WAIT);
  assign req_valid   = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
  assign req_lvl2    = (st_q == ST_L2_REQ);
  assign done_pulse  = (st_q == ST_DONE);
  assign fault_pulse = (st_q == ST_FAULT);
endmodule

// File: rtl/ptw_addr.sv
module ptw_addr
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PTE_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic [VA_W-1:0]       va_in,
  input  logic [PA_W-1:0]       base_in,
  input  logic                  ld_tbl,
  input  logic [PA_W-OFF_W-1:0] tbl_ppn,
  input  logic                  lvl2,
  output logic [PA_W-1:0]       req_addr,
  output logic [OFF_W-1:0]      va_off
);
  localparam int unsigned ENT_SH = $clog2(PTE_W / 8);

  logic [VA_W-1:0] va_q;
  logic [PA_W-1:0] base_q;
  logic [PA_W-1:0] tbl_q;
  logic [IDX_W-1:0] idx [NUM_LEVELS];

  genvar lv;
  generate
    for (lv = 0; lv < NUM_LEVELS; lv++) begin : g_idx
      assign idx[lv] = va_q[OFF_W + IDX_W*(NUM_LEVELS-1-lv) +: IDX_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
      tbl_q  <= '0;
    end else begin
      if (accept) begin
        va_q   <= va_in;
        base_q <= base_in;
      end
      if (ld_tbl) tbl_q <= {tbl_ppn, {OFF_W{1'b0}}};
    end
  end

  logic [PA_W-1:0] sel_base;
  logic [PA_W-1:0] sel_ofs;
  assign sel_base = lvl2 ? tbl_q : base_q;
  assign sel_ofs  = PA_W'({(lvl2 ? idx[1] : idx[0]), {ENT_SH{1'b0}}});
  assign req_addr = sel_base + sel_ofs;
  assign va_off   = va_q[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry.sv
module ptw_entry
  import ptw_pkg::*;
#(
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned PPN_W  = 20,
  parameter int unsigned PERM_W = 3
) (
  input  logic [PTE_W-1:0]  word,
  output logic              present,
  output logic [PPN_W-1:0]  ppn,
  output logic [PERM_W-1:0] perm
);
  assign present = word[PTE_PRESENT_BIT];
  assign ppn     = word[PTE_W-1 -: PPN_W];

  genvar b;
  generate
    for (b = 0; b < PERM_W; b++) begin : g_perm
      assign perm[b] = word[PTE_PERM_LSB + b];
    end
  endgenerate
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned PERM_W = 3,
  localparam int unsigned PPN_W = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [VA_W-1:0]   miss_va,
  input  logic [PA_W-1:0]   pt_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              busy,
  output logic              walk_done,
  output logic              walk_fault,
  output logic              fault_lvl,
  output logic [PPN_W-1:0]  res_ppn,
  output logic [PERM_W-1:0] res_perm,
  output logic [PA_W-1:0]   res_pa
);
  logic accept, ld_tbl, ld_leaf, flt_set, flt_lvl2, idle, req_lvl2;
  logic ent_present;
  logic [PPN_W-1:0]  ent_ppn;
  logic [PERM_W-1:0] ent_perm;
  logic [OFF_W-1:0]  va_off;

  ptw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid),
    .req_ready(mem_req_ready), .rsp_valid(mem_rsp_valid),
    .rsp_present(ent_present), .accept(accept), .ld_tbl(ld_tbl),
    .ld_leaf(ld_leaf), .flt_set(flt_set), .flt_lvl2(flt_lvl2),
    .idle(idle), .req_valid(mem_req_valid), .req_lvl2(req_lvl2),
    .done_pulse(walk_done), .fault_pulse(walk_fault)
  );

  ptw_entry #(.PTE_W(PTE_W), .PPN_W(PPN_W), .PERM_W(PERM_W)) u_entry (
    .word(mem_rsp_data), .present(ent_present), .ppn(ent_ppn), .perm(ent_perm)
  );

  ptw_addr #(.VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
             .PTE_W(PTE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .accept(accept), .va_in(miss_va),
    .base_in(pt_base), .ld_tbl(ld_tbl), .tbl_ppn(ent_ppn),
    .lvl2(req_lvl2), .req_addr(mem_req_addr), .va_off(va_off)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_ppn   <= '0;
      res_perm  <= '0;
      fault_lvl <= 1'b0;
    end else begin
      if (ld_leaf) begin
        res_ppn  <= ent_ppn;
        res_perm <= ent_perm;
      end
      if (flt_set) fault_lvl <= flt_lvl2;
    end
  end

  assign miss_ready = idle;
  assign busy       = !idle;
  assign res_pa     = {res_ppn, va_off};
endmodule

// File: rtl/ptw_checks.sv
module ptw_checks #(
  parameter int unsigned PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            miss_valid,
  input logic            miss_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            busy,
  input logic            walk_done,
  input logic            walk_fault
);
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> !busy);
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> busy);
  p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_done && walk_fault));
  p_done_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done || walk_fault) |=> (!walk_done && !walk_fault && !busy));
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  p_req_in_walk_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);
endmodule

bind ptw_top ptw_checks #(.PA_W(PA_W)) i_ptw_checks (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .busy(busy), .walk_done(walk_done),
  .walk_fault(walk_fault)
);

// File: tb/test_ptw_top.sv
module test_ptw_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic [31:0] miss_va = '0;
  logic [31:0] pt_base = '0;
  logic mem_req_ready = 1'b0;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic miss_ready, mem_req_valid, busy, walk_done, walk_fault, fault_lvl;
  logic [31:0] mem_req_addr;
  logic [19:0] res_ppn;
  logic [2:0]  res_perm;
  logic [31:0] res_pa;

  always #10 clk = ~clk;

  ptw_top i_ptw_top (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_va(miss_va), .pt_base(pt_base), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .busy(busy),
    .walk_done(walk_done), .walk_fault(walk_fault), .fault_lvl(fault_lvl),
    .res_ppn(res_ppn), .res_perm(res_perm), .res_pa(res_pa)
  );

  int n_chk = 0;
  int n_fail = 0;
  localparam logic [31:0] L2_REGION = 32'h0010_0000;

  // memory model state
  logic [31:0] walk_base = '0;
  int lat_cfg = 0, stall_cfg = 0;
  bit spur_cfg = 0;
  logic [31:0] addr_log [4];
  int n_log = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] leaf_word(input int i, input int j);
    logic [19:0] ppn;
    logic [2:0] pm;
    ppn = 20'((i * 37 + j * 11 + 5) & 32'hFFFFF);
    pm  = 3'((i + j) & 7);
    return {ppn, 8'h00, pm, ((j % 7) != 2) ? 1'b1 : 1'b0};
  endfunction

  function automatic logic [31:0] lookup(input logic [31:0] a);
    int i, j;
    if (a >= walk_base && a < walk_base + 32'd4096) begin
      i = int'((a - walk_base) >> 2);
      return {20'(32'h100 + 32'(i)), 11'h0, ((i % 5) != 3) ? 1'b1 : 1'b0};
    end else if (a >= L2_REGION && a < L2_REGION + 32'h0040_0000) begin
      i = int'((a - L2_REGION) >> 12);
      j = int'((a >> 2) & 32'h3FF);
      return leaf_word(i, j);
    end
    return 32'h0;
  endfunction

  // memory responder, acts at falling edges
  initial begin
    bit pend = 0;
    int cnt = 0;
    int wctr = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = lookup(paddr);
          pend = 0;
        end else cnt--;
      end
      if (mem_req_valid && wctr < stall_cfg) begin
        mem_req_ready = 1'b0;
        wctr++;
        if (spur_cfg && !pend && !mem_rsp_valid) begin
          mem_rsp_valid = 1'b1;   // stray response while request stalled (R10)
          mem_rsp_data  = 32'h0;
        end
      end else mem_req_ready = 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1;
        cnt = lat_cfg;
        paddr = mem_req_addr;
        wctr = 0;
        if (n_log < 4) addr_log[n_log] = mem_req_addr;
        n_log++;
      end
    end
  end

  task automatic walk(input int i, input int j, input logic [31:0] base,
                      input bit chg_base, input bit flood);
    logic [31:0] va;
    logic [31:0] leaf;
    bit l1ok, l2ok, ended;
    int guard;
    va = {10'(i), 10'(j), 12'((i * 13 + j * 3) & 12'hFFF)};
    l1ok = (i % 5) != 3;
    leaf = leaf_word(i, j);
    l2ok = leaf[0];
    n_log = 0;
    walk_base = base;
    @(negedge clk);
    chk(miss_ready === 1'b1, "R1 idle ready", 32'(miss_ready), 32'd1);
    miss_valid = 1'b1; miss_va = va; pt_base = base;
    @(negedge clk);
    chk(busy === 1'b1, "R7 busy after accept", 32'(busy), 32'd1);
    if (chg_base) pt_base = base ^ 32'h0004_8000;
    if (flood) begin
      miss_va = ~va;   // held offer while busy (R1)
      chk(miss_ready === 1'b0, "R1 not ready in walk", 32'(miss_ready), 32'd0);
    end else miss_valid = 1'b0;
    ended = 0; guard = 0;
    while (!ended && guard < 500) begin
      if (walk_done || walk_fault) ended = 1;
      else begin
        if (busy !== 1'b1) chk(0, "R7 busy dropped", 32'(busy), 32'd1);
        @(negedge clk); guard++;
      end
    end
    miss_valid = 1'b0;
    chk(ended, "R7 walk ended", 32'(guard), 32'd0);
    chk(busy === 1'b1, "R7 busy on pulse", 32'(busy), 32'd1);
    chk(addr_log[0] === base + 32'(i * 4), "R2 R9 first read", addr_log[0],
        base + 32'(i * 4));
    if (!l1ok) begin
      chk(walk_fault === 1'b1 && walk_done === 1'b0, "R4 fault pulse",
          {walk_done, walk_fault}, 32'd1);
      chk(fault_lvl === 1'b0, "R4 fault level", 32'(fault_lvl), 32'd0);
      chk(n_log == 1, "R4 single read", 32'(n_log), 32'd1);
    end else begin
      chk(n_log == 2, "R3 two reads", 32'(n_log), 32'd2);
      chk(addr_log[1] === L2_REGION + 32'(i * 4096 + j * 4), "R3 second read",
          addr_log[1], L2_REGION + 32'(i * 4096 + j * 4));
      if (!l2ok) begin
        chk(walk_fault === 1'b1 && walk_done === 1'b0, "R5 fault pulse",
            {walk_done, walk_fault}, 32'd1);
        chk(fault_lvl === 1'b1, "R5 fault level", 32'(fault_lvl), 32'd1);
      end else begin
        chk(walk_done === 1'b1 && walk_fault === 1'b0, "R6 done pulse",
            {walk_done, walk_fault}, 32'd2);
        chk(res_ppn === leaf[31:12], "R6 ppn", 32'(res_ppn), 32'(leaf[31:12]));
        chk(res_perm === leaf[3:1], "R6 perm", 32'(res_perm), 32'(leaf[3:1]));
        chk(res_pa === {leaf[31:12], va[11:0]}, "R6 pa", res_pa,
            {leaf[31:12], va[11:0]});
      end
    end
    @(negedge clk);
    chk(!walk_done && !walk_fault && !busy, "R7 pulse one cycle",
        {walk_done, walk_fault, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int il [8] = '{0, 1, 2, 3, 8, 511, 1022, 1023};
    int jl [5] = '{0, 1, 2, 9, 1023};
    int k = 0;
    repeat (3) @(negedge clk);
    chk(miss_ready === 1'b1 && busy === 1'b0, "R1 reset idle",
        {miss_ready, busy}, 32'd2);
    chk(!walk_done && !walk_fault && !mem_req_valid, "R7 reset quiet",
        {walk_done, walk_fault, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 5; b++) begin
        lat_cfg = k % 3;
        stall_cfg = k % 4;   // R8 back-pressure on request
        spur_cfg = (k % 5) == 0 && stall_cfg > 0;   // R10
        walk(il[a], jl[b], (k % 2) ? 32'h0004_0000 : 32'h0000_8000,
             k == 7 || k == 22, k == 11 || k == 31);   // R9, R1
        k++;
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule